// File: doc/BRIEF.md
# Rotated Immediate Operand Shifter

This block builds the second source operand of a 32-bit data-processing instruction. It also produces the carry value that the shifter hands to the flag logic. The block receives the instruction word, the value already read for the shifted register (Rm) and the value read for the shift-amount register (Rs). From these it selects one of three forms:

- a small constant rotated right by an even amount;
- the Rm value shifted by a five-bit constant from the instruction;
- the Rm value shifted by the low byte of Rs.

The current carry flag enters as an input, because several encodings pass it through or shift it in.

A third output tells the flag stage whether the shifter carry should be written. That is true only for the logical opcodes, and only when the set-flags bit is on. The register file, the ALU, the flag registers and condition evaluation sit outside this block. A parameter selects between registered outputs with one cycle of latency (the default) and a purely combinational path.

Top module: `opnd_shifter`

## Requirements
- R1: When instruction bit 25 is 1, the operand is the zero-extended byte in bits 7:0, rotated right by twice the 4-bit value in bits 11:8.
- R2: In the rotated-constant form with a rotate field of 0, the byte passes through unrotated and the carry output equals the carry input.
- R3: In the rotated-constant form with a non-zero rotate field, the carry output equals bit 31 of the rotated operand.
- R4: When bit 25 is 0 and bit 4 is 0, Rm is shifted by the amount in bits 11:7, with the kind given by bits 6:5 (00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right). The carry is the last bit shifted out. A left shift by 0 passes Rm and the carry input through.
- R5: A constant amount of 0 with a logical or arithmetic right shift means a shift by 32. Logical gives 0, arithmetic gives every bit equal to Rm bit 31, and in both cases the carry is Rm bit 31.
- R6: A constant amount of 0 with the rotate kind means rotate-through-carry by one: the result is {carry input, Rm[31:1]} and the carry is Rm[0].
- R7: When bit 25 is 0 and bit 4 is 1, the amount is bits 7:0 of Rs, and bits 31:8 of Rs have no effect. An amount of 0 passes Rm and the carry input through.
- R8: A register amount of exactly 32 with a left or logical right shift gives 0, with carry Rm[0] or Rm[31] respectively. Any register amount above 32 for these kinds gives 0 with carry 0.
- R9: A register amount of 32 or more with an arithmetic shift fills every bit with Rm[31], and the carry is Rm[31]. A non-zero register rotate amount whose low five bits are 0 gives Rm with carry Rm[31]. Any other rotate amount rotates by its low five bits.
- R10: The flag-update output is 1 exactly when bit 20 is 1 and opcode bits 24:21 are one of 0000, 0001, 1000, 1001, 1100, 1101, 1110, 1111.
- R11: With registered outputs, every result appears one clock after its inputs. A synchronous active-high reset drives all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the shifted register |
| rs_val | input | 32 | Value of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| op2_o | output | 32 | Second operand |
| carry_o | output | 1 | Shifter carry-out |
| flag_upd_o | output | 1 | Shifter carry should update the flags |

## Verification
The properties assume that `instr`, `rm_val`, `rs_val` and `carry_in` are known and stable around each rising edge whenever reset is low. They also assume that the field decode is done only from the bit positions stated in the requirements. The stimulus changes inputs only on falling edges, and holds a defined instruction even while reset is asserted. Random register amounts are steered so that the boundary values are hit repeatedly: 0, 31, 32, 33 and multiples of 32. Random Rs upper bits are set to non-zero garbage, so the low-byte rule is always under test.

// File: rtl/opnd_pkg.sv
`timescale 1ns/1ps
package opnd_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  // Opcodes whose carry comes from the shifter rather than the adder
  function automatic logic op_is_logical(input logic [3:0] opc);
    case (opc)
      4'b0000, 4'b0001, 4'b1000, 4'b1001,
      4'b1100, 4'b1101, 4'b1110, 4'b1111: op_is_logical = 1'b1;
      default:                            op_is_logical = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/opnd_imm_rot.sv
`timescale 1ns/1ps
module opnd_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic              cin,
  output logic [DATA_W-1:0] val,
  output logic              cout
);
  localparam int AMT_W = ROT_W + 1;

  logic [AMT_W-1:0]    amt;
  logic [DATA_W-1:0]   ext;
  logic [2*DATA_W-1:0] dbl;

  assign amt = {rot, 1'b0};
  assign ext = {{(DATA_W-IMM_W){1'b0}}, imm};
  assign dbl = {ext, ext} >> amt;
  assign val = dbl[DATA_W-1:0];
  assign cout = (rot == '0) ? cin : dbl[DATA_W-1];

endmodule

// File: rtl/opnd_amt_sel.sv
`timescale 1ns/1ps
module opnd_amt_sel
  import opnd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHC_W  = 5,
  parameter int AMT_W  = 8
) (
  input  logic             by_reg,
  input  logic [SHC_W-1:0] imm_amt,
  input  logic [AMT_W-1:0] rs_byte,
  input  shift_kind_e      kind,
  output logic [AMT_W-1:0] amt,
  output logic             rrx
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  always_comb begin
    rrx = 1'b0;
    amt = '0;
    if (by_reg) begin
      amt = rs_byte;
    end else if (imm_amt != '0) begin
      amt = AMT_W'(imm_amt);
    end else begin
      case (kind)
        SH_LSR, SH_ASR: amt = FULL;
        SH_ROR:         rrx = 1'b1;
        default:        amt = '0;
      endcase
    end
  end

endmodule

// File: rtl/opnd_barrel.sv
`timescale 1ns/1ps
module opnd_barrel
  import opnd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] val,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              rrx,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [SH_W-1:0]     lo;
  logic [SH_W-1:0]     up_idx;
  logic [SH_W-1:0]     dn_idx;
  logic [2*DATA_W-1:0] rot_dbl;
  logic                short_amt;

  assign lo        = amt[SH_W-1:0];
  assign up_idx    = ~lo + 1'b1;
  assign dn_idx    = lo - 1'b1;
  assign rot_dbl   = {val, val} >> lo;
  assign short_amt = (amt < FULL);

  always_comb begin
    res  = val;
    cout = cin;
    if (rrx) begin
      res  = {cin, val[DATA_W-1:1]};
      cout = val[0];
    end else if (amt != '0) begin
      case (kind)
        SH_LSL: begin
          if (short_amt) begin
            res  = val << lo;
            cout = val[up_idx];
          end else begin
            res  = '0;
            cout = (amt == FULL) ? val[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (short_amt) begin
            res  = val >> lo;
            cout = val[dn_idx];
          end else begin
            res  = '0;
            cout = (amt == FULL) ? val[DATA_W-1] : 1'b0;
          end
        end
        SH_ASR: begin
          if (short_amt) begin
            res  = $signed(val) >>> lo;
            cout = val[dn_idx];
          end else begin
            res  = {DATA_W{val[DATA_W-1]}};
            cout = val[DATA_W-1];
          end
        end
        default: begin
          if (lo == '0) begin
            res  = val;
            cout = val[DATA_W-1];
          end else begin
            res  = rot_dbl[DATA_W-1:0];
            cout = val[dn_idx];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/opnd_shifter.sv
`timescale 1ns/1ps
module opnd_shifter
  import opnd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSN_W  = 32,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int SHC_W   = 5,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] instr,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] rs_val,
  input  logic              carry_in,
  output logic [DATA_W-1:0] op2_o,
  output logic              carry_o,
  output logic              flag_upd_o
);
  // Bit positions other decoders depend on
  localparam int B_IMM   = 25;
  localparam int B_SETF  = 20;
  localparam int B_OPC   = 21;
  localparam int B_BYREG = 4;
  localparam int B_KIND  = 5;
  localparam int B_SHC   = 7;
  localparam int B_ROT   = 8;
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic              imm_form;
  logic              by_reg;
  shift_kind_e       kind;
  logic [DATA_W-1:0] imm_op;
  logic              imm_c;
  logic [AMT_W-1:0]  amt;
  logic              rrx;
  logic [DATA_W-1:0] sh_op;
  logic              sh_c;
  logic [DATA_W-1:0] nxt_op;
  logic              nxt_c;
  logic              nxt_f;

  assign imm_form = instr[B_IMM];
  assign by_reg   = instr[B_BYREG];
  assign kind     = shift_kind_e'(instr[B_KIND +: 2]);

  opnd_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm  (instr[IMM_W-1:0]),
    .rot  (instr[B_ROT +: ROT_W]),
    .cin  (carry_in),
    .val  (imm_op),
    .cout (imm_c)
  );

  opnd_amt_sel #(.DATA_W(DATA_W), .SHC_W(SHC_W), .AMT_W(AMT_W)) u_amt (
    .by_reg  (by_reg),
    .imm_amt (instr[B_SHC +: SHC_W]),
    .rs_byte (rs_val[AMT_W-1:0]),
    .kind    (kind),
    .amt     (amt),
    .rrx     (rrx)
  );

  opnd_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_bar (
    .val  (rm_val),
    .kind (kind),
    .amt  (amt),
    .rrx  (rrx),
    .cin  (carry_in),
    .res  (sh_op),
    .cout (sh_c)
  );

  assign nxt_op = imm_form ? imm_op : sh_op;
  assign nxt_c  = imm_form ? imm_c  : sh_c;
  assign nxt_f  = instr[B_SETF] & op_is_logical(instr[B_OPC +: 4]);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          op2_o      <= '0;
          carry_o    <= 1'b0;
          flag_upd_o <= 1'b0;
        end else begin
          op2_o      <= nxt_op;
          carry_o    <= nxt_c;
          flag_upd_o <= nxt_f;
        end
      end

      // R11
      rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (op2_o == '0 && !carry_o && !flag_upd_o));
    end else begin : g_comb
      assign op2_o      = nxt_op;
      assign carry_o    = nxt_c;
      assign flag_upd_o = nxt_f;
    end
  endgenerate

  // R2
  imm_zero_rot_chk: assert property (@(posedge clk) disable iff (rst)
    (imm_form && instr[B_ROT +: ROT_W] == '0) |->
      (nxt_op == DATA_W'(instr[IMM_W-1:0]) && nxt_c == carry_in));

  // R6
  rrx_chk: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && !by_reg && kind == SH_ROR && instr[B_SHC +: SHC_W] == '0) |->
      (nxt_op[DATA_W-1] == carry_in && nxt_c == rm_val[0]));

  // R7
  reg_zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && by_reg && rs_val[AMT_W-1:0] == '0) |->
      (nxt_op == rm_val && nxt_c == carry_in));

  // R8
  far_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && by_reg && rs_val[AMT_W-1:0] > FULL &&
     (kind == SH_LSL || kind == SH_LSR)) |->
      (nxt_op == '0 && !nxt_c));

  // R9
  asr_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && kind == SH_ASR) |-> (nxt_op[DATA_W-1] == rm_val[DATA_W-1]));

endmodule

// File: tb/opnd_shifter_bench.sv
`timescale 1ns/1ps
module opnd_shifter_bench;

  typedef struct {
    logic [31:0] op;
    logic        c;
    logic        f;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] rm_val = '0;
  logic [31:0] rs_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] op2_o;
  logic        carry_o;
  logic        flag_upd_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  opnd_shifter u_opnd_shifter (
    .clk(clk), .rst(rst), .instr(instr), .rm_val(rm_val), .rs_val(rs_val),
    .carry_in(carry_in), .op2_o(op2_o), .carry_o(carry_o), .flag_upd_o(flag_upd_o)
  );

  // Bit-at-a-time reference built from the requirements
  function automatic void model(input logic [31:0] ins, input logic [31:0] rm,
                                input logic [31:0] rs, input logic cin,
                                output logic [31:0] r, output logic c, output logic f);
    logic [1:0] kd;
    int n;
    f = ins[20] && (ins[24:21] inside {4'b0000, 4'b0001, 4'b1000, 4'b1001,
                                       4'b1100, 4'b1101, 4'b1110, 4'b1111});
    if (ins[25]) begin
      r = {24'b0, ins[7:0]};
      c = cin;
      for (int k = 0; k < 2 * int'(ins[11:8]); k++) r = {r[0], r[31:1]};
      if (ins[11:8] != 0) c = r[31];
      return;
    end
    kd = ins[6:5];
    r = rm;
    c = cin;
    n = ins[4] ? int'(rs[7:0]) : int'(ins[11:7]);
    if (!ins[4] && n == 0) begin
      if (kd == 2'b11) begin
        r = {cin, rm[31:1]};
        c = rm[0];
        return;
      end
      if (kd != 2'b00) n = 32;
    end
    for (int k = 0; k < n; k++) begin
      case (kd)
        2'b00: begin c = r[31]; r = r << 1; end
        2'b01: begin c = r[0];  r = r >> 1; end
        2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endfunction

  function automatic string tag_of(input logic [31:0] ins, input logic [31:0] rs);
    if (ins[25]) return (ins[11:8] == 0) ? "R1 R2" : "R1 R3";
    if (!ins[4]) begin
      if (ins[11:7] == 0 && ins[6:5] == 2'b11) return "R6";
      if (ins[11:7] == 0 && ins[6:5] != 2'b00) return "R5";
      return "R4";
    end
    if (rs[7:0] == 0) return "R7";
    if (rs[7:0] >= 32 && ins[6] == 1'b0) return "R8";
    if (rs[7:0] >= 32) return "R9";
    return "R7";
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [31:0] rm,
                       input logic [31:0] rs, input logic cin);
    exp_t e;
    @(negedge clk);
    instr = ins; rm_val = rm; rs_val = rs; carry_in = cin;
    model(ins, rm, rs, cin, e.op, e.c, e.f);
    e.tag = tag_of(ins, rs);
    q.push_back(e);
  endtask

  // Register-form instruction builder
  function automatic logic [31:0] rins(input logic [3:0] opc, input logic s,
                                       input logic byreg, input logic [1:0] kd,
                                       input logic [4:0] amt5);
    return {4'hE, 3'b000, opc, s, 4'h1, 4'h2, amt5, kd, byreg, 4'h3};
  endfunction

  function automatic logic [31:0] iins(input logic [3:0] opc, input logic s,
                                       input logic [3:0] rot, input logic [7:0] imm);
    return {4'hE, 3'b001, opc, s, 4'h1, 4'h2, rot, imm};
  endfunction

  // Monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        checks++;
        if (op2_o !== e.op || carry_o !== e.c) begin
          errors++;
          $display("FAIL %s: op2=%h carry=%b expected op2=%h carry=%b",
                   e.tag, op2_o, carry_o, e.op, e.c);
        end
        checks++;
        if (flag_upd_o !== e.f) begin
          errors++;
          $display("FAIL R10: flag_upd=%b expected %b", flag_upd_o, e.f);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ri, rm, rs;
    logic [7:0] amts [8];
    amts = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd64, 8'd96, 8'd255};
    // R11: outputs cleared while reset is held
    instr = iins(4'hD, 1'b1, 4'h0, 8'hFF); rm_val = 32'hFFFF_FFFF; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (op2_o !== '0 || carry_o !== 1'b0 || flag_upd_o !== 1'b0) begin
      errors++;
      $display("FAIL R11: op2=%h c=%b f=%b expected all zero", op2_o, carry_o, flag_upd_o);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3 immediate form
    drive(iins(4'hD, 1'b1, 4'h0, 8'hA5), 32'h0, 32'h0, 1'b1);
    drive(iins(4'hD, 1'b1, 4'h1, 8'h03), 32'h0, 32'h0, 1'b0);
    drive(iins(4'h4, 1'b1, 4'h4, 8'h80), 32'h0, 32'h0, 1'b1);
    drive(iins(4'h0, 1'b1, 4'hF, 8'hFF), 32'h0, 32'h0, 1'b0);
    // R4 R5 R6 constant amounts
    drive(rins(4'hD, 1'b1, 1'b0, 2'b00, 5'd0), 32'h8000_0001, 32'h0, 1'b1);
    drive(rins(4'hD, 1'b1, 1'b0, 2'b00, 5'd1), 32'h8000_0001, 32'h0, 1'b0);
    drive(rins(4'hD, 1'b1, 1'b0, 2'b01, 5'd0), 32'h8000_0001, 32'h0, 1'b0);
    drive(rins(4'hD, 1'b1, 1'b0, 2'b10, 5'd0), 32'h8000_0000, 32'h0, 1'b0);
    drive(rins(4'hD, 1'b1, 1'b0, 2'b11, 5'd0), 32'h0000_0003, 32'h0, 1'b1);
    drive(rins(4'hD, 1'b1, 1'b0, 2'b11, 5'd4), 32'h1234_5678, 32'h0, 1'b0);
    // R7 R8 R9 register amounts, upper Rs bits set as garbage
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 8; j++)
        drive(rins(4'hC, 1'b1, 1'b1, 2'(k), 5'd0), 32'hC000_0001,
              32'hDEAD_BE00 | 32'(amts[j]), j[0]);
    // R10 every opcode with and without set-flags
    for (int op = 0; op < 16; op++) begin
      drive(rins(4'(op), 1'b1, 1'b0, 2'b00, 5'd3), 32'h0F0F_0F0F, 32'h0, 1'b0);
      drive(iins(4'(op), 1'b0, 4'h2, 8'h11), 32'h0, 32'h0, 1'b1);
    end
    // Random mix steered toward boundaries
    for (int k = 0; k < 400; k++) begin
      ri = $urandom;
      rm = $urandom;
      rs = $urandom;
      if (k % 3 == 0) rs[7:0] = amts[$urandom_range(0, 7)];
      ri[31:28] = 4'hE;
      ri[27:26] = 2'b00;
      if (!ri[25]) ri[7] = ri[4] ? 1'b0 : ri[7];
      drive(ri, rm, rs, 1'($urandom));
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule